// File: doc/BRIEF.md
# Time-Multiplexed 64-Point Inverse FFT Engine

This block turns one frame of 64 complex frequency-domain samples into 64 complex time-domain samples, as needed once per OFDM symbol in a transmitter. A single four-input radix-4 butterfly does every step of the transform. The transform has three radix-4 passes of sixteen butterflies each. A pass counter and a butterfly counter pick the four operands from a 64-entry working store and steer the four results back into the same slots. At the end of each pass, a fixed shuffle reorders the whole store.

A frame enters on a valid/ready input port. The input is ready only when the engine sits at pass 0, butterfly 0. The first butterfly runs in the same cycle that the frame is taken. The finished frame appears on a valid/ready output port during the last butterfly cycle (pass 2, butterfly 15). If the output is not ready in that cycle, the engine freezes with all state unchanged until the consumer takes the frame. A frame costs 48 cycles when neither side stalls, so a symbol every 4 µs needs a clock of at least 12 MHz.

Each butterfly computes a 4-point inverse DFT of its operands. It multiplies each result by a positive-exponent twiddle factor drawn from a quarter-wave cosine table. It then scales the result down by 4 with rounding, so the whole transform carries an overall factor of 1/64.

Top module: `ifft64_folded`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: While `in_valid` is low and the engine waits for a frame, `in_ready` stays 1, `out_valid` stays 0, and no frame is taken.
- R3: For input components within ±16383, each output sample n equals round((1/64)·Σk x[k]·e^{+j2πnk/64}) within ±4 LSB. Each sample is 2·DW bits wide. Sample n of either bus sits at bits [2·DW·n + 2·DW−1 : 2·DW·n]: the real part is the upper DW bits and the imaginary part is the lower DW bits, both two's complement. Samples are in natural order.
- R4: `out_valid` first rises in the 47th cycle after the cycle in which the frame was taken.
- R5: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1 and `out_data` unchanged.
- R6: In the cycle after a frame leaves (`out_valid` and `out_ready` both high at an edge), `in_ready` is 1, so frames can follow one another every 48 cycles.
- R7: Between taking a frame and releasing its result, `in_ready` is 0. Any `in_valid` or `in_data` activity in that window has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input frame offered |
| in_ready | output | 1 | Engine takes the frame at this edge if in_valid is high |
| in_data | input | 128·DW | 64 complex frequency-domain samples |
| out_valid | output | 1 | Result frame present |
| out_ready | input | 1 | Consumer takes the result at this edge |
| out_data | output | 128·DW | 64 complex time-domain samples |

## Verification
The bench builds the engine with the default 16-bit sample width. This is the width at which the quarter-wave twiddle table and the two-bit-per-pass scaling are exactly balanced against the ±16383 input range. That setting brings several cases within reach: full-scale tones at the first and last bins (which exercise twiddle sign handling in all four quadrants), a time-domain impulse, and random frames whose intermediate values approach the edges of the register range. Random output stalls and mid-frame input activity exercise the freeze on the last butterfly and the one-frame-in-flight rule.

// File: rtl/ifft_pkg.sv
package ifft_pkg;
  localparam int NPT   = 64;          // transform points
  localparam int NSTG  = 3;           // radix-4 passes
  localparam int NBF   = NPT / 4;     // butterflies per pass
  localparam int AW    = 2 * NSTG;    // store address width
  localparam int BIW   = AW - 2;      // butterfly counter width
  localparam int TWW   = 16;          // twiddle word width
  localparam int TWF   = 14;          // twiddle fraction bits
  localparam int SCL   = 2;           // right shift per pass

  // reverse the base-4 digits of a store address (3 digits)
  function automatic logic [AW-1:0] digit_rev(input logic [AW-1:0] a);
    return {a[1:0], a[3:2], a[5:4]};
  endfunction

  // source slot of the inter-pass shuffle: new[4b+m] = old[b + NBF*m]
  function automatic logic [AW-1:0] shuffle_src(input logic [AW-1:0] a);
    return {a[1:0], a[AW-1:2]};
  endfunction
endpackage

// File: rtl/ifft_twiddle.sv
module ifft_twiddle
  import ifft_pkg::*;
(
  input  logic [AW-1:0]           k,
  output logic signed [TWW-1:0]   w_re,
  output logic signed [TWW-1:0]   w_im
);
  // cos(2*pi*i/64) in Q14 for i = 0..16
  function automatic logic signed [TWW-1:0] qtab(input int i);
    case (i)
      0:  return 16'sd16384;  1:  return 16'sd16305;
      2:  return 16'sd16069;  3:  return 16'sd15679;
      4:  return 16'sd15137;  5:  return 16'sd14449;
      6:  return 16'sd13623;  7:  return 16'sd12665;
      8:  return 16'sd11585;  9:  return 16'sd10394;
      10: return 16'sd9102;   11: return 16'sd7723;
      12: return 16'sd6270;   13: return 16'sd4756;
      14: return 16'sd3196;   15: return 16'sd1606;
      default: return 16'sd0;
    endcase
  endfunction

  function automatic logic signed [TWW-1:0] wcos(input logic [AW-1:0] m);
    int v;
    v = int'(m);
    if (v <= 16)      return qtab(v);
    else if (v <= 32) return -qtab(32 - v);
    else if (v <= 48) return -qtab(v - 32);
    else              return qtab(64 - v);
  endfunction

  logic [AW-1:0] k_sin;
  assign k_sin = k + AW'(48);   // sin(x) = cos(x - quarter turn)
  assign w_re  = wcos(k);
  assign w_im  = wcos(k_sin);
endmodule

// File: rtl/ifft_bfly4.sv
module ifft_bfly4
  import ifft_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [1:0]              stg,
  input  logic [BIW-1:0]          bidx,
  input  logic signed [DW-1:0]    x_re [4],
  input  logic signed [DW-1:0]    x_im [4],
  output logic signed [DW-1:0]    y_re [4],
  output logic signed [DW-1:0]    y_im [4]
);
  localparam int BW = DW + 2;
  localparam int PW = BW + TWW + 1;
  localparam int SH = TWF + SCL;
  localparam logic signed [PW-1:0] RND  = PW'(1) <<< (SH - 1);
  localparam logic signed [PW-1:0] VMAX = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] VMIN = -PW'(1 << (DW - 1));

  function automatic logic signed [BW-1:0] ext(input logic signed [DW-1:0] v);
    return BW'(v);
  endfunction

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
    if (v > VMAX)      return DW'(VMAX);
    else if (v < VMIN) return DW'(VMIN);
    else               return DW'(v);
  endfunction

  logic signed [BW-1:0] a_r, a_i, b_r, b_i, c_r, c_i, d_r, d_i;
  logic signed [BW-1:0] s_re [4];
  logic signed [BW-1:0] s_im [4];
  logic [BIW-1:0] msk;

  assign a_r = ext(x_re[0]) + ext(x_re[2]);
  assign a_i = ext(x_im[0]) + ext(x_im[2]);
  assign b_r = ext(x_re[0]) - ext(x_re[2]);
  assign b_i = ext(x_im[0]) - ext(x_im[2]);
  assign c_r = ext(x_re[1]) + ext(x_re[3]);
  assign c_i = ext(x_im[1]) + ext(x_im[3]);
  assign d_r = ext(x_re[1]) - ext(x_re[3]);
  assign d_i = ext(x_im[1]) - ext(x_im[3]);

  // 4-point inverse DFT: out[m] = sum_i x[i] * j^(m*i)
  assign s_re[0] = a_r + c_r;  assign s_im[0] = a_i + c_i;
  assign s_re[2] = a_r - c_r;  assign s_im[2] = a_i - c_i;
  assign s_re[1] = b_r - d_i;  assign s_im[1] = b_i + d_r;
  assign s_re[3] = b_r + d_i;  assign s_im[3] = b_i - d_r;

  // twiddle exponent = m * (bidx with the low 2*stg bits cleared); zero on the last pass
  always_comb begin
    case (stg)
      2'd0:    msk = {BIW{1'b1}};
      2'd1:    msk = {{(BIW-2){1'b1}}, 2'b00};
      default: msk = '0;
    endcase
  end

  for (genvar m = 0; m < 4; m++) begin : g_leg
    logic [AW-1:0]          k;
    logic signed [TWW-1:0]  w_re, w_im;
    logic signed [PW-1:0]   p_re, p_im;

    assign k = AW'(m) * AW'(bidx & msk);

    ifft_twiddle u_tw (.k(k), .w_re(w_re), .w_im(w_im));

    assign p_re = PW'(s_re[m]) * PW'(w_re) - PW'(s_im[m]) * PW'(w_im) + RND;
    assign p_im = PW'(s_re[m]) * PW'(w_im) + PW'(s_im[m]) * PW'(w_re) + RND;
    assign y_re[m] = sat(p_re >>> SH);
    assign y_im[m] = sat(p_im >>> SH);
  end
endmodule

// File: rtl/ifft_seq.sv
module ifft_seq
  import ifft_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            out_ready,
  output logic [1:0]      stg,
  output logic [BIW-1:0]  bidx,
  output logic            first,
  output logic            last,
  output logic            pass_end,
  output logic            adv
);
  assign first    = (stg == 2'd0) && (bidx == '0);
  assign pass_end = (bidx == BIW'(NBF - 1));
  assign last     = (stg == 2'(NSTG - 1)) && pass_end;
  assign adv      = (!first || in_valid) && (!last || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg  <= '0;
      bidx <= '0;
    end else if (adv) begin
      if (pass_end) begin
        bidx <= '0;
        stg  <= last ? 2'd0 : stg + 2'd1;
      end else begin
        bidx <= bidx + BIW'(1);
      end
    end
  end

  assert_stage_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stg < 2'(NSTG));

  assert_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !out_ready) |=> ($stable(stg) && $stable(bidx)));
endmodule

// File: rtl/ifft64_folded.sv
module ifft64_folded
  import ifft_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NPT*2*DW-1:0]    in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NPT*2*DW-1:0]    out_data
);
  localparam int SW = 2 * DW;

  logic [1:0]      stg;
  logic [BIW-1:0]  bidx;
  logic            first, last, pass_end, adv;

  ifft_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .stg(stg), .bidx(bidx), .first(first), .last(last),
    .pass_end(pass_end), .adv(adv)
  );

  logic signed [DW-1:0] st_re   [NPT];
  logic signed [DW-1:0] st_im   [NPT];
  logic signed [DW-1:0] base_re [NPT];
  logic signed [DW-1:0] base_im [NPT];
  logic signed [DW-1:0] wr_re   [NPT];
  logic signed [DW-1:0] wr_im   [NPT];
  logic signed [DW-1:0] nx_re   [NPT];
  logic signed [DW-1:0] nx_im   [NPT];
  logic signed [DW-1:0] op_re   [4];
  logic signed [DW-1:0] op_im   [4];
  logic signed [DW-1:0] rs_re   [4];
  logic signed [DW-1:0] rs_im   [4];

  // operand selection: slot bidx + NBF*i
  for (genvar i = 0; i < 4; i++) begin : g_op
    logic [AW-1:0] sel;
    assign sel      = {2'(i), bidx};
    assign op_re[i] = base_re[sel];
    assign op_im[i] = base_im[sel];
  end

  ifft_bfly4 #(.DW(DW)) u_bf (
    .stg(stg), .bidx(bidx), .x_re(op_re), .x_im(op_im),
    .y_re(rs_re), .y_im(rs_im)
  );

  for (genvar a = 0; a < NPT; a++) begin : g_slot
    localparam logic [AW-1:0] AD = AW'(a);
    localparam logic [AW-1:0] SRC = shuffle_src(AW'(a));
    localparam logic [AW-1:0] DR = digit_rev(AW'(a));

    // fresh frame on the accepting cycle, fed-back pass results otherwise
    assign base_re[a] = first ? in_data[SW*a + DW +: DW] : st_re[a];
    assign base_im[a] = first ? in_data[SW*a +: DW]      : st_im[a];

    // write-back steering: results land in the slots they came from
    assign wr_re[a] = (AD[BIW-1:0] == bidx) ? rs_re[AD[AW-1:BIW]] : base_re[a];
    assign wr_im[a] = (AD[BIW-1:0] == bidx) ? rs_im[AD[AW-1:BIW]] : base_im[a];

    // fixed shuffle at the end of every pass
    assign nx_re[a] = pass_end ? wr_re[SRC] : wr_re[a];
    assign nx_im[a] = pass_end ? wr_im[SRC] : wr_im[a];

    // after the last shuffle, time sample n sits at slot digit_rev(n)
    assign out_data[SW*a + DW +: DW] = nx_re[DR];
    assign out_data[SW*a +: DW]      = nx_im[DR];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_re[a] <= '0;
        st_im[a] <= '0;
      end else if (adv) begin
        st_re[a] <= nx_re[a];
        st_im[a] <= nx_im[a];
      end
    end
  end

  assign in_ready  = first;
  assign out_valid = last;

  // latency check counter: cycles since the frame was taken
  logic [6:0] since_in;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           since_in <= '0;
    else if (in_valid && in_ready)        since_in <= 7'd1;
    else if (since_in != '0 && !out_valid && since_in != 7'h7f)
                                          since_in <= since_in + 7'd1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since_in == 7'd47));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_idle_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (in_ready && !out_valid));

  assert_reopen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

  assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
endmodule

// File: tb/sim_ifft64_folded.sv
module sim_ifft64_folded;
  localparam int DW  = 16;
  localparam int NPT = 64;
  localparam int NF  = 14;
  localparam int TOL = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [NPT*2*DW-1:0] in_data, out_data;

  always #10 clk = ~clk;   // 50 MHz

  ifft64_folded #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0;
  int rx = 0;
  int xr [NF][NPT];
  int xi [NF][NPT];
  int er [NF][NPT];
  int ei [NF][NPT];
  int acc_cyc [NF];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference scaled inverse DFT (R3)
  task automatic make_ref(input int f);
    for (int n = 0; n < NPT; n++) begin
      real sr, si, th;
      sr = 0.0; si = 0.0;
      for (int k = 0; k < NPT; k++) begin
        th = 2.0 * 3.14159265358979 * real'((n * k) % NPT) / real'(NPT);
        sr += real'(xr[f][k]) * $cos(th) - real'(xi[f][k]) * $sin(th);
        si += real'(xr[f][k]) * $sin(th) + real'(xi[f][k]) * $cos(th);
      end
      er[f][n] = int'(sr / real'(NPT));
      ei[f][n] = int'(si / real'(NPT));
    end
  endtask

  task automatic build(input int f);
    for (int k = 0; k < NPT; k++) begin
      xr[f][k] = 0; xi[f][k] = 0;
      case (f)
        0: ;                                                  // all zero
        1: if (k == 0) xr[f][k] = 16000;                      // DC bin
        2: begin xr[f][k] = 16383; xi[f][k] = -16383; end     // time impulse
        3: if (k == 1)  xr[f][k] = 16383;                     // first bin tone
        4: if (k == 63) xi[f][k] = -16383;                    // last bin tone
        5: begin xr[f][k] = (k % 2) ? -16383 : 16383; xi[f][k] = (k % 3 == 0) ? 16383 : -16383; end
        default: begin
          xr[f][k] = int'($urandom_range(32766)) - 16383;
          xi[f][k] = int'($urandom_range(32766)) - 16383;
        end
      endcase
    end
    make_ref(f);
  endtask

  // driver
  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset handshake", {in_ready, out_valid}, 2);
    repeat (5) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R2 idle wait", {in_ready, out_valid}, 2);
    for (int f = 0; f < NF; f++) begin
      build(f);
      repeat ($urandom_range(2)) @(negedge clk);
      for (int k = 0; k < NPT; k++) begin
        in_data[2*DW*k + DW +: DW] = DW'(xr[f][k]);
        in_data[2*DW*k +: DW]      = DW'(xi[f][k]);
      end
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      acc_cyc[f] = cyc;
      @(negedge clk);
      if (f % 3 == 1) begin
        // R7: activity on the input while busy must not be taken
        in_data = ~in_data;
        repeat (10) @(negedge clk);
        chk(in_ready === 1'b0, "R7 busy input", int'(in_ready), 0);
      end
      in_valid = 1'b0;
    end
  end

  // consumer and checks
  logic [NPT*2*DW-1:0] held;
  bit hold_chk = 0, reopen_chk = 0, pv = 0;
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = (rx < 2) || ($urandom_range(3) != 0);
      #1;
      if (rst_n) begin
        if (reopen_chk) begin
          chk(in_ready === 1'b1, "R6 ready after release", int'(in_ready), 1);
          reopen_chk = 0;
        end
        if (out_valid && !pv && rx < NF)
          chk(cyc - acc_cyc[rx] == 47, "R4 latency", cyc - acc_cyc[rx], 47);
        pv = out_valid;
        if (hold_chk) begin
          chk(out_valid === 1'b1 && out_data === held, "R5 stall hold",
              int'(out_valid), 1);
          hold_chk = 0;
        end
        if (out_valid && !out_ready) begin
          held = out_data;
          hold_chk = 1;
        end
        if (out_valid && out_ready && rx < NF) begin
          int bad_n, ar, ai;
          bad_n = -1;
          for (int n = 0; n < NPT; n++) begin
            int dr, di;
            dr = int'($signed(out_data[2*DW*n + DW +: DW])) - er[rx][n];
            di = int'($signed(out_data[2*DW*n +: DW])) - ei[rx][n];
            if (bad_n < 0 && (dr > TOL || dr < -TOL || di > TOL || di < -TOL)) bad_n = n;
          end
          if (bad_n >= 0) begin
            ar = int'($signed(out_data[2*DW*bad_n + DW +: DW]));
            ai = int'($signed(out_data[2*DW*bad_n +: DW]));
            $display("FAIL R3 frame %0d sample %0d actual=(%0d,%0d) expected=(%0d,%0d)",
                     rx, bad_n, ar, ai, er[rx][bad_n], ei[rx][bad_n]);
          end
          nchk++;
          if (bad_n >= 0) nfail++;
          chk(in_ready === 1'b0, "R7 no intake with result pending", int'(in_ready), 0);
          rx++;
          reopen_chk = 1;
        end
      end
    end
  end

  // end of run and watchdog
  initial begin
    fork
      wait (rx == NF && !reopen_chk);
      begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL R4 watchdog frames=%0d expected=%0d", rx, NF);
      end
    join_any
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule